// File: doc/BRIEF.md
# Channel Status Block Buffer Cascade

This block carries AES3 channel status bits from a receiver to a transmitter when the two run at unrelated sample rates. Status bits are never resampled. Whole 192-frame blocks for both channels travel through three cascaded stores: a fill store written bit by bit from the receiver, a middle store, and a drain store that feeds the transmitter bit by bit. A block moves from the fill store to the middle store only once all 192 frames have arrived after a block start. The middle store is copied into the drain store whenever the transmitter begins a new block.

Because whole blocks move only at block boundaries, a fast transmitter sends the same middle contents again, and a slow one lets later received blocks overwrite earlier ones before they are sent. Every transmitted block is an exact copy of one buffered block. A byte-wide register port reads and writes the middle store only. Firmware can inspect or rewrite the status, for example to patch sample-count fields, between transmit boundaries.

Top module: `csbuf_cascade`

## Requirements
- R1: After reset all three stores hold zero: every in-range port read returns 0x00, and a transmitted block after a transmit start is all zeros.
- R2: Channel A middle-store byte k (0..23) is at port address 0x20+k and channel B byte k is at 0x38+k. A write followed by a read of the same address returns the written value.
- R3: Within a byte, bit 7 holds the earlier serial bit: stream bit i of a channel lands in byte i/8 at bit position 7-(i mod 8). Bit 7 of byte 0 of channel A is the consumer/professional flag.
- R4: A receive block starts with a valid channel A bit that has rx_blk_start=1 (frame 0). Bits go A then B for each frame. After the channel B bit of frame 191 the whole block is copied into the middle store, which is readable two clock edges after that bit is sampled.
- R5: A block cut short by a new block start is discarded. The middle store keeps its previous contents, and the new block proceeds from frame 0.
- R6: A one-cycle tx_blk_start copies the middle store into the drain store. Port writes made after that copy do not change the bits sent for that block.
- R7: With tx_bit_req high, tx_cbit returns, in the same cycle, the drain-store bit of the current frame for the channel on tx_chan. A channel B request advances the frame, wrapping from 191 to 0. Repeated transmit starts without a new received block resend identical contents.
- R8: When two complete blocks are received before the next transmit start, only the later one is sent.
- R9: When a port write and a fill-to-middle transfer hit the same clock edge, the addressed byte takes the written value and every other byte takes the received block.
- R10: When a fill-to-middle transfer and a transmit start hit the same clock edge, the drain store receives the old middle contents.
- R11: Addresses outside 0x20..0x4F read as 0x00, and writes to them change no byte of the middle store.
- R12: Valid receive bits that arrive when no block start has armed the fill logic are ignored and never reach the middle store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_bit_vld | input | 1 | Receive status bit strobe |
| rx_chan | input | 1 | Channel of the received bit, 0 = A, 1 = B |
| rx_blk_start | input | 1 | With a valid channel A bit, marks frame 0 |
| rx_cbit | input | 1 | Received channel status bit |
| tx_blk_start | input | 1 | One-cycle strobe before frame 0 of a transmit block |
| tx_bit_req | input | 1 | Transmit status bit request |
| tx_chan | input | 1 | Channel of the requested bit, 0 = A, 1 = B |
| tx_cbit | output | 1 | Requested status bit, combinational |
| reg_addr | input | 8 | Register port byte address |
| reg_wr | input | 1 | Register port write strobe |
| reg_wdata | input | 8 | Register port write data |
| reg_rdata | output | 8 | Register port read data, combinational |

## Verification
The assertions assume that tx_blk_start never coincides with tx_bit_req, and that receive bits alternate between channel A and channel B within a frame. The stimulus tasks always drive a complete A-then-B pair per frame and pulse the transmit start in a cycle of its own before any request. The same-edge cases for R9 and R10 are reached by raising the write or the transmit start in the cycle right after the last receive bit, which is the cycle in which the transfer is pending.

// File: rtl/csbuf_pkg.sv
package csbuf_pkg;
  localparam int unsigned CS_FRAMES = 192;
  localparam int unsigned CS_ADDR_W = 8;

  typedef enum logic {
    CH_A = 1'b0,
    CH_B = 1'b1
  } cs_chan_e;
endpackage

// File: rtl/csbuf_rx_fill.sv
module csbuf_rx_fill
  import csbuf_pkg::*;
#(
  parameter int unsigned FRAMES = CS_FRAMES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_vld,
  input  logic              chan,
  input  logic              blk_start,
  input  logic              cbit,
  output logic [FRAMES-1:0] blk_a,
  output logic [FRAMES-1:0] blk_b,
  output logic              xfer
);
  localparam int unsigned FW = $clog2(FRAMES);
  localparam logic [FW-1:0] LAST = FW'(FRAMES - 1);

  logic [FRAMES-1:0] a_q, a_d, b_q, b_d;
  logic [FW-1:0]     frm_q, frm_d, idx;
  logic              armed_q, armed_d, xfer_q, xfer_d;
  logic              start_hit, take;

  always_comb begin
    start_hit = bit_vld && blk_start && (chan == CH_A);
    take      = bit_vld && (armed_q || start_hit);
    idx       = start_hit ? '0 : frm_q;
    a_d       = a_q;
    b_d       = b_q;
    frm_d     = frm_q;
    armed_d   = armed_q;
    xfer_d    = 1'b0;
    if (take) begin
      if (chan == CH_A) begin
        a_d[idx] = cbit;
        if (start_hit) begin
          armed_d = 1'b1;
          frm_d   = '0;
        end
      end else begin
        b_d[idx] = cbit;
        if (idx == LAST) begin
          xfer_d  = 1'b1;
          armed_d = 1'b0;
          frm_d   = '0;
        end else begin
          frm_d = idx + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q     <= '0;
      b_q     <= '0;
      frm_q   <= '0;
      armed_q <= 1'b0;
      xfer_q  <= 1'b0;
    end else begin
      xfer_q <= xfer_d;
      if (take) begin
        a_q     <= a_d;
        b_q     <= b_d;
        frm_q   <= frm_d;
        armed_q <= armed_d;
      end
    end
  end

  assign blk_a = a_q;
  assign blk_b = b_q;
  assign xfer  = xfer_q;

  p_single_xfer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_q |=> !xfer_q);
  p_early_start_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_hit && armed_q) |=> !xfer_q);
  p_unarmed_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !start_hit) |=> ($stable(a_q) && $stable(b_q) && !xfer_q));
endmodule

// File: rtl/csbuf_mid_store.sv
module csbuf_mid_store
  import csbuf_pkg::*;
#(
  parameter int unsigned       FRAMES    = CS_FRAMES,
  parameter int unsigned       ADDR_W    = CS_ADDR_W,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer,
  input  logic [FRAMES-1:0] in_a,
  input  logic [FRAMES-1:0] in_b,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic [FRAMES-1:0] mid_a,
  output logic [FRAMES-1:0] mid_b
);
  localparam int unsigned BYTES = FRAMES / 8;
  localparam int unsigned BW    = $clog2(BYTES);
  localparam logic [ADDR_W-1:0] NB  = ADDR_W'(BYTES);
  localparam logic [ADDR_W-1:0] N2B = ADDR_W'(2 * BYTES);

  logic [1:0][BYTES-1:0][7:0] mem_q, mem_d, in_bytes;
  logic [ADDR_W-1:0]          off;
  logic                       hit, sel, wr_hit;
  logic [BW-1:0]              bidx;

  for (genvar k = 0; k < BYTES; k++) begin : g_byte
    for (genvar j = 0; j < 8; j++) begin : g_bit
      assign in_bytes[0][k][7-j] = in_a[8*k+j];
      assign in_bytes[1][k][7-j] = in_b[8*k+j];
      assign mid_a[8*k+j]        = mem_q[0][k][7-j];
      assign mid_b[8*k+j]        = mem_q[1][k][7-j];
    end
  end

  always_comb begin
    off    = addr - BASE_ADDR;
    hit    = (addr >= BASE_ADDR) && (off < N2B);
    sel    = (off >= NB);
    bidx   = BW'(sel ? (off - NB) : off);
    wr_hit = wr_en && hit;
    rdata  = hit ? mem_q[sel][bidx] : 8'h00;
  end

  always_comb begin
    mem_d = xfer ? in_bytes : mem_q;
    if (wr_hit) begin
      mem_d[sel][bidx] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else if (xfer || wr_hit) begin
      mem_q <= mem_d;
    end
  end

  p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (mem_q[$past(sel)][$past(bidx)] == $past(wdata)));
  p_block_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !wr_en) |=> ((mid_a == $past(in_a)) && (mid_b == $past(in_b))));
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer && !wr_hit) |=> ($stable(mid_a) && $stable(mid_b)));
endmodule

// File: rtl/csbuf_tx_drain.sv
module csbuf_tx_drain
  import csbuf_pkg::*;
#(
  parameter int unsigned FRAMES = CS_FRAMES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blk_start,
  input  logic              bit_req,
  input  logic              chan,
  input  logic [FRAMES-1:0] mid_a,
  input  logic [FRAMES-1:0] mid_b,
  output logic              cbit
);
  localparam int unsigned FW = $clog2(FRAMES);
  localparam logic [FW-1:0] LAST = FW'(FRAMES - 1);

  logic [FRAMES-1:0] oa_q, ob_q;
  logic [FW-1:0]     frm_q, frm_d;
  logic              step;

  always_comb begin
    step  = bit_req && (chan == CH_B) && !blk_start;
    frm_d = frm_q;
    if (blk_start) begin
      frm_d = '0;
    end else if (step) begin
      frm_d = (frm_q == LAST) ? '0 : frm_q + 1'b1;
    end
    cbit = bit_req && ((chan == CH_B) ? ob_q[frm_q] : oa_q[frm_q]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oa_q  <= '0;
      ob_q  <= '0;
      frm_q <= '0;
    end else begin
      if (blk_start) begin
        oa_q <= mid_a;
        ob_q <= mid_b;
      end
      if (blk_start || step) begin
        frm_q <= frm_d;
      end
    end
  end

  p_copy_on_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start |=> ((oa_q == $past(mid_a)) && (ob_q == $past(mid_b))));
  p_hold_between_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_start |=> ($stable(oa_q) && $stable(ob_q)));
  p_frame_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && (frm_q == LAST)) |=> (frm_q == '0));
endmodule

// File: rtl/csbuf_cascade.sv
module csbuf_cascade
  import csbuf_pkg::*;
#(
  parameter int unsigned       FRAMES    = CS_FRAMES,
  parameter int unsigned       ADDR_W    = CS_ADDR_W,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_bit_vld,
  input  logic              rx_chan,
  input  logic              rx_blk_start,
  input  logic              rx_cbit,
  input  logic              tx_blk_start,
  input  logic              tx_bit_req,
  input  logic              tx_chan,
  output logic              tx_cbit,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [FRAMES-1:0] fill_a, fill_b, mid_a, mid_b;
  logic              fill_xfer;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  csbuf_rx_fill #(.FRAMES(FRAMES)) u_fill (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .bit_vld   (rx_bit_vld),
    .chan      (rx_chan),
    .blk_start (rx_blk_start),
    .cbit      (rx_cbit),
    .blk_a     (fill_a),
    .blk_b     (fill_b),
    .xfer      (fill_xfer)
  );

  csbuf_mid_store #(
    .FRAMES    (FRAMES),
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
  ) u_mid (
    .clk   (clk),
    .rst_n (rst_int_n),
    .xfer  (fill_xfer),
    .in_a  (fill_a),
    .in_b  (fill_b),
    .wr_en (reg_wr),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .mid_a (mid_a),
    .mid_b (mid_b)
  );

  csbuf_tx_drain #(.FRAMES(FRAMES)) u_drain (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .blk_start (tx_blk_start),
    .bit_req   (tx_bit_req),
    .chan      (tx_chan),
    .mid_a     (mid_a),
    .mid_b     (mid_b),
    .cbit      (tx_cbit)
  );
endmodule

// File: tb/csbuf_cascade_tb_top.sv
`timescale 1ns/1ps
module csbuf_cascade_tb_top;
  localparam int NF = 192;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_bit_vld = 1'b0, rx_chan = 1'b0, rx_blk_start = 1'b0, rx_cbit = 1'b0;
  logic       tx_blk_start = 1'b0, tx_bit_req = 1'b0, tx_chan = 1'b0;
  logic       tx_cbit;
  logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00, reg_rdata;
  logic       reg_wr = 1'b0;

  int errs = 0;
  int checks = 0;

  always #2 clk = ~clk;

  csbuf_cascade dut_i (
    .clk(clk), .rst_n(rst_n),
    .rx_bit_vld(rx_bit_vld), .rx_chan(rx_chan), .rx_blk_start(rx_blk_start), .rx_cbit(rx_cbit),
    .tx_blk_start(tx_blk_start), .tx_bit_req(tx_bit_req), .tx_chan(tx_chan), .tx_cbit(tx_cbit),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // port vectors: {write, addr, data, expected read}
  localparam logic [24:0] PVEC [14] = '{
    {1'b1, 8'h20, 8'hA5, 8'h00}, {1'b0, 8'h20, 8'h00, 8'hA5},
    {1'b1, 8'h37, 8'h3C, 8'h00}, {1'b0, 8'h37, 8'h00, 8'h3C},
    {1'b1, 8'h38, 8'h81, 8'h00}, {1'b0, 8'h38, 8'h00, 8'h81},
    {1'b1, 8'h4F, 8'h7E, 8'h00}, {1'b0, 8'h4F, 8'h00, 8'h7E},
    {1'b1, 8'h1F, 8'hFF, 8'h00}, {1'b0, 8'h1F, 8'h00, 8'h00},
    {1'b1, 8'h50, 8'hFF, 8'h00}, {1'b0, 8'h50, 8'h00, 8'h00},
    {1'b0, 8'h21, 8'h00, 8'h00}, {1'b0, 8'h00, 8'h00, 8'h00}
  };

  function automatic logic bitval(int unsigned seed, int ch, int i);
    logic [31:0] h;
    if (seed == 0) return 1'b0;
    h = (seed ^ 32'(i * 37 + ch * 1009)) * 32'd2654435761;
    return h[19];
  endfunction

  // R3: stream bit 8k+j sits at bit 7-j of byte k
  function automatic logic [7:0] exp_byte(int unsigned seed, int ch, int k);
    logic [7:0] b;
    for (int j = 0; j < 8; j++) b[7-j] = bitval(seed, ch, 8 * k + j);
    return b;
  endfunction

  task automatic chk8(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(string tag, logic [7:0] a, logic [7:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk8(tag, reg_rdata, exp);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rx_send(int unsigned seed, int nfr, bit do_start,
                         bit wr_done, logic [7:0] wa, logic [7:0] wd, bit tx_done);
    for (int f = 0; f < nfr; f++) begin
      for (int ch = 0; ch < 2; ch++) begin
        @(negedge clk);
        rx_bit_vld   = 1'b1;
        rx_chan      = ch[0];
        rx_blk_start = do_start && (f == 0) && (ch == 0);
        rx_cbit      = bitval(seed, ch, f);
      end
    end
    @(negedge clk);
    rx_bit_vld = 1'b0; rx_blk_start = 1'b0;
    if (wr_done) begin reg_wr = 1'b1; reg_addr = wa; reg_wdata = wd; end
    if (tx_done) tx_blk_start = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; tx_blk_start = 1'b0;
    @(negedge clk);
  endtask

  task automatic tx_start();
    @(negedge clk);
    tx_blk_start = 1'b1;
    @(negedge clk);
    tx_blk_start = 1'b0;
  endtask

  task automatic tx_read(string tag, int unsigned seed);
    int bad = 0;
    logic first_act = 1'b0, first_exp = 1'b0;
    for (int f = 0; f < NF; f++) begin
      for (int ch = 0; ch < 2; ch++) begin
        @(negedge clk);
        tx_bit_req = 1'b1; tx_chan = ch[0];
        #1;
        if (tx_cbit !== bitval(seed, ch, f)) begin
          if (bad == 0) begin first_act = tx_cbit; first_exp = bitval(seed, ch, f); end
          bad++;
        end
      end
    end
    @(negedge clk);
    tx_bit_req = 1'b0;
    checks++;
    if (bad != 0) begin
      errs++;
      $display("FAIL %s: %0d bits differ, first actual=%0b expected=%0b", tag, bad, first_act, first_exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    rd_chk("R1 reset 0x20", 8'h20, 8'h00);
    rd_chk("R1 reset 0x4F", 8'h4F, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd_chk("R1 after release 0x38", 8'h38, 8'h00);
    tx_start();
    tx_read("R1 zero block sent", 0);

    // R2 / R11: table walk on the port
    for (int v = 0; v < 14; v++) begin
      if (PVEC[v][24]) wr(PVEC[v][23:16], PVEC[v][15:8]);
      else if (PVEC[v][23:16] >= 8'h20 && PVEC[v][23:16] <= 8'h4F)
        rd_chk("R2 port readback", PVEC[v][23:16], PVEC[v][7:0]);
      else
        rd_chk("R11 out of range", PVEC[v][23:16], PVEC[v][7:0]);
    end

    // R12: unarmed bits ignored
    rx_send(32'h0707, NF, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0);
    rd_chk("R12 unarmed A0", 8'h20, 8'hA5);
    rd_chk("R12 unarmed B0", 8'h38, 8'h81);

    // R4 / R3: full block lands in middle store, MSB-first per byte
    rx_send(32'h1111, NF, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0);
    for (int k = 0; k < 24; k++) begin
      rd_chk("R3 R4 block A", 8'(8'h20 + k), exp_byte(32'h1111, 0, k));
      rd_chk("R3 R4 block B", 8'(8'h38 + k), exp_byte(32'h1111, 1, k));
    end

    // R6 / R7: copy on start, later writes not seen, resend unchanged
    tx_start();
    wr(8'h20, 8'hFF);
    tx_read("R6 copy isolates later writes", 32'h1111);
    wr(8'h20, exp_byte(32'h1111, 0, 0));
    tx_start();
    tx_read("R7 resend first", 32'h1111);
    tx_start();
    tx_read("R7 resend second", 32'h1111);

    // R5: truncated block discarded
    rx_send(32'h4444, 100, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0);
    rd_chk("R5 partial kept old A5", 8'h25, exp_byte(32'h1111, 0, 5));
    rd_chk("R5 partial kept old B8", 8'h40, exp_byte(32'h1111, 1, 8));
    rx_send(32'h2222, NF, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0);
    rd_chk("R5 restart A0", 8'h20, exp_byte(32'h2222, 0, 0));
    rd_chk("R5 restart B23", 8'h4F, exp_byte(32'h2222, 1, 23));

    // R8: two received blocks before one start, later one sent
    rx_send(32'h3333, NF, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0);
    tx_start();
    tx_read("R8 later block sent", 32'h3333);

    // R10: transfer and transmit start on the same edge
    rx_send(32'h5555, NF, 1'b1, 1'b0, 8'h00, 8'h00, 1'b1);
    tx_read("R10 drain gets old middle", 32'h3333);
    rd_chk("R10 middle has new A3", 8'h23, exp_byte(32'h5555, 0, 3));

    // R9: port write and transfer on the same edge
    rx_send(32'h6666, NF, 1'b1, 1'b1, 8'h3A, 8'h5A, 1'b0);
    rd_chk("R9 written byte wins", 8'h3A, 8'h5A);
    rd_chk("R9 neighbour from block", 8'h39, exp_byte(32'h6666, 1, 1));
    rd_chk("R9 channel A from block", 8'h2A, exp_byte(32'h6666, 0, 10));

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule